// File: doc/BRIEF.md
# Parallel Multi-Channel Serial ADC Reader

This block is a serial master that reads a bank of identical converters at the same moment. Every converter shares one active-low chip select and one serial clock. Each converter returns its bits on its own data line. On a start pulse, the block lowers the chip select and runs a fixed number of lead clock pulses whose data it discards. It then runs one pulse per data bit and samples every data line on each of those pulses. Each sample is shifted into that channel's own accumulator, so all channel words are assembled most-significant bit first in parallel.

The serial clock rate comes from a divider. Its half period in system cycles is derived from the system clock frequency and a maximum serial clock frequency. The defaults keep the serial clock at or below 800 kHz from a 250 MHz system clock.

When the last pulse ends, the chip select rises and stays high for at least one serial clock period. All channel results are then published together with a one-cycle valid pulse. A start that arrives while a sequence is running is dropped.

Top module: `par_adc_capture`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, busy and valid are low, and every result is zero.
- R2: A start pulse sampled while idle lowers the chip select and raises busy on the next cycle. The serial clock then stays low for the first half period.
- R3: Each sequence issues exactly LEAD_CLKS + DATA_BITS serial clock pulses. Each pulse is high for HALF_DIV system cycles. HALF_DIV = ceil(SYS_CLK_HZ / (2 * SCLK_MAX_HZ)).
- R4: Data present on the lines during the first LEAD_CLKS pulses does not reach any result.
- R5: Each data line is sampled in the last system cycle of each high half of the data pulses. The first data pulse supplies the result MSB and the last supplies its LSB.
- R6: Channel c's word comes only from adcDin[c] and is placed at results[c*DATA_BITS +: DATA_BITS].
- R7: The chip select rises in the same cycle as the falling edge of the last pulse. The serial clock is never high while the chip select is high.
- R8: After a sequence, the chip select stays high for exactly 2*HALF_DIV*CS_GAP_CLKS cycles with busy still high. Then valid pulses for exactly one cycle, the results update in that cycle, and busy is low from that cycle on.
- R9: A start pulse while busy is high, during the clocked phase or during the chip-select gap, is ignored. The running sequence is unchanged and no new sequence follows.
- R10: Results hold their value whenever valid is low, whatever the data lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a sequence |
| adcDin | input | NUM_CH | Serial data line of each converter |
| adcCsN | output | 1 | Shared active-low chip select |
| adcSclk | output | 1 | Shared serial clock, idles low |
| busy | output | 1 | High from accepted start until the valid pulse |
| resultValid | output | 1 | One-cycle pulse marking fresh results |
| results | output | NUM_CH*DATA_BITS | Packed channel words, channel 0 in the low bits |

## Verification
Some rules are checked by assertions on every cycle. The serial clock is never high while the chip select is high. The chip select falls only after a start seen while idle. Each chip-select low window holds the full pulse count. A new start always follows the full high gap. Valid lasts one cycle, and the results never move outside it. Other behaviour can only be shown by the bench's scenarios with known codes on each line. These include MSB-first assembly, the discarding of lead bits, the mapping from channel to field, the exact gap length, and the high time of each pulse.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } capState_t;

  typedef struct packed {
    logic clr;
    logic shift;
    logic commit;
  } capStrobe_t;
endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int HALF_DIV    = 157,
  parameter int LEAD_CLKS   = 3,
  parameter int DATA_BITS   = 12,
  parameter int CS_GAP_CLKS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       csN,
  output logic       sclk,
  output logic       busy,
  output capStrobe_t strobe
);
  localparam int TOTAL   = LEAD_CLKS + DATA_BITS;
  localparam int HALVES  = 2 * TOTAL;
  localparam int GAP_CYC = 2 * HALF_DIV * CS_GAP_CLKS;
  localparam int DIV_W   = $clog2(HALF_DIV) + 1;
  localparam int HALF_W  = $clog2(HALVES) + 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1) + 1;
  localparam int PUL_W   = $clog2(TOTAL + 1) + 1;

  capState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              divEnd, lastHalf, gapEnd, pastLead;

  assign divEnd   = (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastHalf = (halfCnt == HALF_W'(HALVES - 1));
  assign gapEnd   = (gapCnt == GAP_W'(GAP_CYC - 1));
  assign pastLead = ({1'b0, halfCnt[HALF_W-1:1]} >= HALF_W'(LEAD_CLKS));

  always_comb begin
    strobe.clr    = (state == ST_IDLE) && start;
    strobe.shift  = (state == ST_ACTIVE) && halfCnt[0] && divEnd && pastLead;
    strobe.commit = (state == ST_GAP) && gapEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      halfCnt <= '0;
      gapCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ACTIVE;
            divCnt  <= '0;
            halfCnt <= '0;
          end
        end
        ST_ACTIVE: begin
          if (divEnd) begin
            divCnt <= '0;
            if (lastHalf) begin
              state  <= ST_GAP;
              gapCnt <= '0;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapEnd) state <= ST_IDLE;
          else        gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN  = (state != ST_ACTIVE);
  assign sclk = (state == ST_ACTIVE) && halfCnt[0];
  assign busy = (state != ST_IDLE);

  // Checker state: cycles of chip select high, and pulses in a window.
  logic [GAP_W-1:0] csHighCnt;
  logic [PUL_W-1:0] pulseCnt;
  logic             sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighCnt <= GAP_W'(GAP_CYC);
      pulseCnt  <= '0;
      sclkQ     <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (!csN)                              csHighCnt <= '0;
      else if (csHighCnt < GAP_W'(GAP_CYC))  csHighCnt <= csHighCnt + 1'b1;
      if (strobe.clr)                        pulseCnt <= '0;
      else if (sclk && !sclkQ)               pulseCnt <= pulseCnt + 1'b1;
    end
  end

  p_sclk_only_selected_r7: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  p_cs_fall_needs_idle_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> ($past(start) && !$past(busy)));

  p_pulse_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (pulseCnt == PUL_W'(TOTAL)));

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |-> (csHighCnt >= GAP_W'(GAP_CYC)));
endmodule

// File: rtl/adc_cap_datapath.sv
module adc_cap_datapath
  import adc_cap_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int DATA_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  capStrobe_t                  strobe,
  input  logic [NUM_CH-1:0]           din,
  output logic                        validQ,
  output logic [NUM_CH*DATA_BITS-1:0] resultQ
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_BITS-1:0] acc;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             acc <= '0;
      else if (strobe.clr)   acc <= '0;
      else if (strobe.shift) acc <= {acc[DATA_BITS-2:0], din[c]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              resultQ[c*DATA_BITS +: DATA_BITS] <= '0;
      else if (strobe.commit) resultQ[c*DATA_BITS +: DATA_BITS] <= acc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.commit;
  end

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> $stable(resultQ));
endmodule

// File: rtl/par_adc_capture.sv
module par_adc_capture
  import adc_cap_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_BITS   = 12,
  parameter int LEAD_CLKS   = 3,
  parameter int SYS_CLK_HZ  = 250_000_000,
  parameter int SCLK_MAX_HZ = 800_000,
  parameter int CS_GAP_CLKS = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NUM_CH-1:0]           adcDin,
  output logic                        adcCsN,
  output logic                        adcSclk,
  output logic                        busy,
  output logic                        resultValid,
  output logic [NUM_CH*DATA_BITS-1:0] results
);
  localparam int HALF_DIV = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);

  capStrobe_t strobe;

  adc_cap_ctrl #(
    .HALF_DIV   (HALF_DIV),
    .LEAD_CLKS  (LEAD_CLKS),
    .DATA_BITS  (DATA_BITS),
    .CS_GAP_CLKS(CS_GAP_CLKS)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .csN   (adcCsN),
    .sclk  (adcSclk),
    .busy  (busy),
    .strobe(strobe)
  );

  adc_cap_datapath #(
    .NUM_CH   (NUM_CH),
    .DATA_BITS(DATA_BITS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .din    (adcDin),
    .validQ (resultValid),
    .resultQ(results)
  );
endmodule

// File: tb/par_adc_capture_tb_top.sv
module par_adc_capture_tb_top;
  localparam int NCH   = 8;
  localparam int DB    = 12;
  localparam int LEAD  = 3;
  localparam int SYS   = 250_000_000;
  localparam int SMAX  = 25_000_000;
  localparam int GAPC  = 1;
  localparam int H     = (SYS + 2 * SMAX - 1) / (2 * SMAX);
  localparam int GAP   = 2 * H * GAPC;
  localparam int TOTAL = LEAD + DB;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [NCH-1:0]    adcDin = '0;
  logic              adcCsN, adcSclk, busy, resultValid;
  logic [NCH*DB-1:0] results;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  par_adc_capture #(
    .NUM_CH(NCH), .DATA_BITS(DB), .LEAD_CLKS(LEAD),
    .SYS_CLK_HZ(SYS), .SCLK_MAX_HZ(SMAX), .CS_GAP_CLKS(GAPC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .adcDin(adcDin),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .busy(busy),
    .resultValid(resultValid), .results(results)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(adcCsN == 1'b1, "R1", "csN", adcCsN, 1);
    chk(adcSclk == 1'b0, "R1", "sclk", adcSclk, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(resultValid == 1'b0, "R1", "valid", resultValid, 0);
    chk(results == '0, "R1", "results", results, 0);
  endtask

  // Runs one sequence, driving code bits on each line and checking timing.
  task automatic run_seq(input logic [NCH*DB-1:0] codes, input logic [NCH-1:0] leadPat,
                         input bit pokeStart);
    int pulses = 0;
    int highLen = 0;
    int badHigh = 0;
    int gapCnt = 0;
    bit prevSclk = 1'b0;
    bit selErr = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(adcCsN == 1'b0, "R2", "csN after start", adcCsN, 0);
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(adcSclk == 1'b0, "R2", "sclk first half", adcSclk, 0);
    while (adcCsN == 1'b0 && pulses <= TOTAL + 2) begin
      start = 1'b0;
      if (adcSclk) begin
        if (!prevSclk) pulses++;
        highLen++;
      end else begin
        if (prevSclk) begin
          if (highLen != H) badHigh++;
          highLen = 0;
        end
        for (int c = 0; c < NCH; c++)
          adcDin[c] = (pulses < LEAD) ? leadPat[c] : codes[c*DB + (DB - 1 - (pulses - LEAD))];
      end
      if (pokeStart && pulses == 7 && adcSclk) start = 1'b1;
      prevSclk = adcSclk;
      @(negedge clk);
    end
    start = 1'b0;
    if (prevSclk && highLen != H) badHigh++;
    chk(adcSclk == 1'b0, "R7", "sclk low as csN rises", adcSclk, 0);
    chk(prevSclk == 1'b1, "R7", "csN rise at last fall", prevSclk, 1);
    chk(pulses == TOTAL, "R3", "pulse count", pulses, TOTAL);
    chk(badHigh == 0, "R3", "pulses with wrong high time", badHigh, 0);
    adcDin = ~leadPat;
    while (!resultValid && gapCnt <= GAP + 4) begin
      if (adcCsN != 1'b1 || busy != 1'b1) selErr = 1'b1;
      start = (pokeStart && gapCnt == 2);
      gapCnt++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(!selErr, "R8", "csN and busy high in gap", selErr, 0);
    chk(gapCnt == GAP, "R8", "gap length", gapCnt, GAP);
    chk(busy == 1'b0, "R8", "busy low at valid", busy, 0);
    for (int c = 0; c < NCH; c++)
      chk(results[c*DB +: DB] == codes[c*DB +: DB], "R4 R5 R6", $sformatf("channel %0d word", c),
          results[c*DB +: DB], codes[c*DB +: DB]);
    @(negedge clk);
    chk(resultValid == 1'b0, "R8", "valid one cycle", resultValid, 0);
  endtask

  task automatic test_ramp();
    logic [NCH*DB-1:0] codes;
    for (int c = 0; c < NCH; c++) codes[c*DB +: DB] = DB'(12'h200 * (c + 1) + c);
    run_seq(codes, '1, 1'b0);
  endtask

  task automatic test_extremes();
    logic [NCH*DB-1:0] codes;
    for (int c = 0; c < NCH; c++) codes[c*DB +: DB] = c[0] ? 12'hFFF : 12'h000;
    run_seq(codes, 8'h55, 1'b0);
    for (int c = 0; c < NCH; c++) codes[c*DB +: DB] = c[0] ? 12'h001 : 12'h800;
    run_seq(codes, 8'hAA, 1'b0);
  endtask

  task automatic test_ignore_start();
    logic [NCH*DB-1:0] codes;
    bit relaunch = 1'b0;
    for (int c = 0; c < NCH; c++) codes[c*DB +: DB] = DB'(12'hA5C ^ (c * 12'h111));
    run_seq(codes, 8'hF0, 1'b1);
    repeat (2 * GAP) begin
      if (adcCsN == 1'b0 || busy == 1'b1) relaunch = 1'b1;
      @(negedge clk);
    end
    chk(!relaunch, "R9", "no sequence from ignored starts", relaunch, 0);
  endtask

  task automatic test_hold();
    logic [NCH*DB-1:0] snap = results;
    bit moved = 1'b0;
    for (int i = 0; i < 40; i++) begin
      adcDin = NCH'(i * 37 + 5);
      @(negedge clk);
      if (results != snap || resultValid) moved = 1'b1;
    end
    chk(!moved, "R10", "results hold without valid", results, snap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_ramp();
    test_extremes();
    test_ignore_start();
    test_hold();
    test_ramp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule